// File: doc/BRIEF.md
# Serial NOR Flash Program and Erase Sequencer

This block sits on the host side of a single-lane SPI link to a serial NOR flash. It takes one request at a time: program part of a page, erase a 4 KB sector, erase a 64 KB block, or erase the whole array. For programming, the data bytes come from a separate byte stream with a valid/ready handshake. The block runs the full flash sequence for each request. It first reads the flash status register to learn the current block-protect setting. If the target lies in the protected region, it refuses the request. Otherwise it sends a write-enable frame, then the program or erase frame. It then polls the status register at a programmable interval until the write-in-progress bit clears, or until a programmable number of polls has been used up.

Programming never leaves the 256-byte page that holds the start address. The block clips the byte count at the page end and takes from the stream only the bytes it sends. The caller must have erased the target page beforehand; the block does not check this. The outcome is reported with a one-cycle done pulse, together with a protection-error flag and a timeout flag. Both flags hold their value until the next request is accepted.

Top module: `flash_pe_seq`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, busy and done are 0, req_ready is 1 and wr_ready is 0.
- R2: Every accepted request first issues a status read frame: opcode 0x05, then one byte clocked in. The block-protect value is taken from bits 5:2 of that byte.
- R3: Protection rule for block-protect value bp. If bp is 0, nothing is protected. If bp is 15, the whole array is protected. For bp from 1 to 14, the top min(2^(bp-1), 64) 64 KB blocks are protected, with the block index taken from address bits 21:16. A chip erase is protected whenever bp is not 0. A protected request ends with done and prot_err set, and no frame other than the status read is sent.
- R4: Each program or erase frame is preceded by a write-enable frame that carries opcode 0x06 alone, framed by its own chip-select pulse.
- R5: req_op selects the operation: 0 is page program (opcode 0x02), 1 is sector erase (0x20), 2 is block erase (0xD8) and 3 is chip erase (0xC7). The first three send a 24-bit address, most significant byte first and zero-extended from the 22-bit req_addr. Chip erase sends no address.
- R6: A page program sends min(req_len_m1+1, 256 - req_addr[7:0]) data bytes. Each byte is taken from the stream in the cycle where wr_valid and wr_ready are both 1. wr_ready is raised only while a data byte is still owed.
- R7: After the command frame, the block waits at least poll_interval cycles with chip select high, then reads the status register. It repeats this while status bit 0 is 1, and ends with done, with both flags clear, once bit 0 reads 0.
- R8: If poll_limit polls in a row all show bit 0 at 1, the request ends with done and timeout set. A poll that shows bit 0 at 0 always wins, even when it is the last poll allowed.
- R9: The SPI link runs in mode 0. spi_sclk idles low and is low whenever chip select is high. Bytes are sent most significant bit first. spi_mosi does not change while spi_sclk is high. Input bits are sampled on the rising edge.
- R10: done is a single-cycle pulse. busy is 1 from the cycle after acceptance until done. req_ready equals the inverse of busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted (idle) |
| req_op | input | 2 | 0 page program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | 22 | Byte address in the array |
| req_len_m1 | input | 8 | Program byte count minus one |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data byte offered |
| wr_ready | output | 1 | Program data byte taken when valid |
| poll_interval | input | 16 | Wait cycles before each status poll |
| poll_limit | input | 16 | Maximum number of status polls |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| prot_err | output | 1 | Last request refused by protection |
| timeout | output | 1 | Last request gave up polling |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |

## Verification
The poll that reads the write-in-progress bit as clear and the poll counter reaching poll_limit can occur in the same cycle. When they do, the block must decide between a clean completion and a timeout. The bench provokes this case with a flash model that reports busy for exactly poll_limit minus one polls, so the last poll allowed is the first clean one. It expects done without the timeout flag and exactly poll_limit status reads after the command. A second run keeps the flash busy for longer than poll_limit polls and expects the timeout flag after the same number of reads.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_PAGE   = 2'd0,
    OP_SECTOR = 2'd1,
    OP_BLOCK  = 2'd2,
    OP_CHIP   = 2'd3
  } fop_e;

  typedef enum logic [3:0] {
    S_IDLE  = 4'd0,
    S_ST_OP = 4'd1,
    S_ST_RD = 4'd2,
    S_CHECK = 4'd3,
    S_WREN  = 4'd4,
    S_GAP   = 4'd5,
    S_CMD   = 4'd6,
    S_ADDR  = 4'd7,
    S_DATA  = 4'd8,
    S_WAIT  = 4'd9,
    S_FIN   = 4'd10
  } seq_st_e;

  localparam logic [7:0] CODE_STATUS = 8'h05;
  localparam logic [7:0] CODE_WEN    = 8'h06;
  localparam logic [7:0] CODE_PROG   = 8'h02;
  localparam logic [7:0] CODE_SECT   = 8'h20;
  localparam logic [7:0] CODE_BLK    = 8'hD8;
  localparam logic [7:0] CODE_CHIP   = 8'hC7;

  function automatic logic [7:0] op_to_code(fop_e op);
    case (op)
      OP_PAGE:   return CODE_PROG;
      OP_SECTOR: return CODE_SECT;
      OP_BLOCK:  return CODE_BLK;
      default:   return CODE_CHIP;
    endcase
  endfunction

endpackage

// File: rtl/flash_spi_byte.sv
module flash_spi_byte #(
  parameter int CLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int DIV_W = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_HALF - 1);

  logic             active_q, active_d;
  logic             sclk_q, sclk_d;
  logic             done_q, done_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic [7:0]       rx_q, rx_d;

  always_comb begin
    active_d = active_q;
    sclk_d   = sclk_q;
    done_d   = 1'b0;
    div_d    = div_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    rx_d     = rx_q;
    if (start && !active_q) begin
      active_d = 1'b1;
      sh_d     = tx_byte;
      div_d    = '0;
      bit_d    = '0;
      sclk_d   = 1'b0;
    end else if (active_q) begin
      if (div_q == DIV_LAST) begin
        div_d = '0;
        if (!sclk_q) begin
          sclk_d = 1'b1;
          rx_d   = {rx_q[6:0], miso};
        end else begin
          sclk_d = 1'b0;
          sh_d   = {sh_q[6:0], 1'b0};
          if (bit_q == 3'd7) begin
            active_d = 1'b0;
            done_d   = 1'b1;
          end else begin
            bit_d = bit_q + 3'd1;
          end
        end
      end else begin
        div_d = div_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      rx_q     <= '0;
    end else begin
      active_q <= active_d;
      sclk_q   <= sclk_d;
      done_q   <= done_d;
      div_q    <= div_d;
      bit_q    <= bit_d;
      sh_q     <= sh_d;
      rx_q     <= rx_d;
    end
  end

  assign busy    = active_q;
  assign done    = done_q;
  assign rx_byte = rx_q;
  assign sclk    = sclk_q;
  assign mosi    = sh_q[7];

  // R9: data to the flash holds while the clock is high
  assert_mosi_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R9: a new byte is only launched on an idle engine
  assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active_q);

endmodule

// File: rtl/flash_prot_check.sv
module flash_prot_check
  import flash_seq_pkg::*;
#(
  parameter int ARRAY_AW  = 22,
  parameter int BLK_SHIFT = 16
) (
  input  logic [3:0]          bp,
  input  fop_e                op,
  input  logic [ARRAY_AW-1:0] addr,
  output logic                hit
);
  localparam int BLK_W = ARRAY_AW - BLK_SHIFT;
  localparam logic [31:0] NUM_BLK = 32'(1) << BLK_W;

  logic [BLK_W-1:0] blk;
  logic [31:0]      span;
  logic [31:0]      blk_ext;

  assign blk     = addr[ARRAY_AW-1:BLK_SHIFT];
  assign blk_ext = 32'(blk);

  always_comb begin
    if (bp == 4'd0) begin
      span = '0;
    end else if (bp == 4'd15) begin
      span = NUM_BLK;
    end else begin
      span = 32'd1 << (bp - 4'd1);
      if (span > NUM_BLK) span = NUM_BLK;
    end
  end

  always_comb begin
    if (op == OP_CHIP) hit = (bp != 4'd0);
    else               hit = (span != 32'd0) && (blk_ext >= (NUM_BLK - span));
  end

endmodule

// File: rtl/flash_poll_timer.sv
module flash_poll_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] interval,
  input  logic             tick_en,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                          cnt_d = interval;
    else if (tick_en && cnt_q != '0)   cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
  import flash_seq_pkg::*;
#(
  parameter int ARRAY_AW  = 22,
  parameter int PAGE_W    = 8,
  parameter int BLK_SHIFT = 16,
  parameter int CNT_W     = 16,
  parameter int CLK_HALF  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_op,
  input  logic [ARRAY_AW-1:0] req_addr,
  input  logic [PAGE_W-1:0]   req_len_m1,
  input  logic [7:0]          wr_data,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [CNT_W-1:0]    poll_interval,
  input  logic [CNT_W-1:0]    poll_limit,
  output logic                busy,
  output logic                done,
  output logic                prot_err,
  output logic                timeout,
  output logic                spi_sclk,
  output logic                spi_cs_n,
  output logic                spi_mosi,
  input  logic                spi_miso
);
  localparam int LEN_W = PAGE_W + 1;
  localparam logic [LEN_W-1:0] PAGE_BYTES = LEN_W'(1) << PAGE_W;
  localparam int CMD_AW = 24;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  seq_st_e             st_q, st_d;
  fop_e                op_q, op_d;
  logic [ARRAY_AW-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]    rem_q, rem_d;
  logic [1:0]          idx_q, idx_d;
  logic                launched_q, launched_d;
  logic                polling_q, polling_d;
  logic [CNT_W-1:0]    pcnt_q, pcnt_d;
  logic [7:0]          stat_q, stat_d;
  logic                cs_n_q, cs_n_d;
  logic                prot_q, prot_d;
  logic                tmo_q, tmo_d;

  logic       eng_start, eng_busy, eng_done;
  logic [7:0] eng_tx, eng_rx;
  logic       tmr_load, tmr_expired;
  logic       prot_hit, enter_wait, byte_state;
  logic [CMD_AW-1:0] cmd_addr;
  logic [LEN_W-1:0]  room, want;

  assign cmd_addr = CMD_AW'(addr_q);
  assign room     = PAGE_BYTES - {1'b0, req_addr[PAGE_W-1:0]};
  assign want     = {1'b0, req_len_m1} + LEN_W'(1);

  flash_spi_byte #(.CLK_HALF(CLK_HALF)) u_byte (
    .clk     (clk),
    .rst_n   (rst_i),
    .start   (eng_start),
    .tx_byte (eng_tx),
    .busy    (eng_busy),
    .done    (eng_done),
    .rx_byte (eng_rx),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .miso    (spi_miso)
  );

  flash_prot_check #(.ARRAY_AW(ARRAY_AW), .BLK_SHIFT(BLK_SHIFT)) u_prot (
    .bp   (stat_q[5:2]),
    .op   (op_q),
    .addr (addr_q),
    .hit  (prot_hit)
  );

  flash_poll_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_i),
    .load     (tmr_load),
    .interval (poll_interval),
    .tick_en  (st_q == S_WAIT),
    .expired  (tmr_expired)
  );

  // byte to send in each byte-carrying state
  always_comb begin
    byte_state = 1'b1;
    case (st_q)
      S_ST_OP: eng_tx = CODE_STATUS;
      S_ST_RD: eng_tx = 8'h00;
      S_WREN:  eng_tx = CODE_WEN;
      S_CMD:   eng_tx = op_to_code(op_q);
      S_ADDR: begin
        case (idx_q)
          2'd0:    eng_tx = cmd_addr[23:16];
          2'd1:    eng_tx = cmd_addr[15:8];
          default: eng_tx = cmd_addr[7:0];
        endcase
      end
      S_DATA:  eng_tx = wr_data;
      default: begin
        eng_tx     = 8'h00;
        byte_state = 1'b0;
      end
    endcase
  end

  assign wr_ready  = (st_q == S_DATA) && !launched_q;
  assign eng_start = byte_state && !launched_q && ((st_q != S_DATA) || wr_valid);

  always_comb begin
    st_d       = st_q;
    op_d       = op_q;
    addr_d     = addr_q;
    rem_d      = rem_q;
    idx_d      = idx_q;
    launched_d = launched_q;
    polling_d  = polling_q;
    pcnt_d     = pcnt_q;
    stat_d     = stat_q;
    cs_n_d     = cs_n_q;
    prot_d     = prot_q;
    tmo_d      = tmo_q;
    tmr_load   = 1'b0;
    enter_wait = 1'b0;

    if (eng_start)                 launched_d = 1'b1;
    else if (launched_q && eng_done) launched_d = 1'b0;

    case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          op_d      = fop_e'(req_op);
          addr_d    = req_addr;
          rem_d     = (want < room) ? want : room;
          polling_d = 1'b0;
          prot_d    = 1'b0;
          tmo_d     = 1'b0;
          cs_n_d    = 1'b0;
          st_d      = S_ST_OP;
        end
      end
      S_ST_OP: if (eng_done) st_d = S_ST_RD;
      S_ST_RD: begin
        if (eng_done) begin
          cs_n_d = 1'b1;
          stat_d = eng_rx;
          if (!polling_q) begin
            st_d = S_CHECK;
          end else if (!eng_rx[0]) begin
            st_d = S_FIN;
          end else if (({1'b0, pcnt_q} + (CNT_W+1)'(1)) >= {1'b0, poll_limit}) begin
            tmo_d = 1'b1;
            st_d  = S_FIN;
          end else begin
            pcnt_d   = pcnt_q + CNT_W'(1);
            tmr_load = 1'b1;
            st_d     = S_WAIT;
          end
        end
      end
      S_CHECK: begin
        if (prot_hit) begin
          prot_d = 1'b1;
          st_d   = S_FIN;
        end else begin
          cs_n_d = 1'b0;
          st_d   = S_WREN;
        end
      end
      S_WREN: begin
        if (eng_done) begin
          cs_n_d = 1'b1;
          st_d   = S_GAP;
        end
      end
      S_GAP: begin
        cs_n_d = 1'b0;
        st_d   = S_CMD;
      end
      S_CMD: begin
        if (eng_done) begin
          idx_d = 2'd0;
          if (op_q == OP_CHIP) enter_wait = 1'b1;
          else                 st_d = S_ADDR;
        end
      end
      S_ADDR: begin
        if (eng_done) begin
          if (idx_q == 2'd2) begin
            if (op_q == OP_PAGE) st_d = S_DATA;
            else                 enter_wait = 1'b1;
          end else begin
            idx_d = idx_q + 2'd1;
          end
        end
      end
      S_DATA: begin
        if (eng_done) begin
          rem_d = rem_q - LEN_W'(1);
          if (rem_q == LEN_W'(1)) enter_wait = 1'b1;
        end
      end
      S_WAIT: begin
        if (tmr_expired) begin
          cs_n_d = 1'b0;
          st_d   = S_ST_OP;
        end
      end
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase

    if (enter_wait) begin
      cs_n_d    = 1'b1;
      polling_d = 1'b1;
      pcnt_d    = '0;
      tmr_load  = 1'b1;
      st_d      = S_WAIT;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q       <= S_IDLE;
      op_q       <= OP_PAGE;
      addr_q     <= '0;
      rem_q      <= '0;
      idx_q      <= '0;
      launched_q <= 1'b0;
      polling_q  <= 1'b0;
      pcnt_q     <= '0;
      stat_q     <= '0;
      cs_n_q     <= 1'b1;
      prot_q     <= 1'b0;
      tmo_q      <= 1'b0;
    end else begin
      st_q       <= st_d;
      op_q       <= op_d;
      addr_q     <= addr_d;
      rem_q      <= rem_d;
      idx_q      <= idx_d;
      launched_q <= launched_d;
      polling_q  <= polling_d;
      pcnt_q     <= pcnt_d;
      stat_q     <= stat_d;
      cs_n_q     <= cs_n_d;
      prot_q     <= prot_d;
      tmo_q      <= tmo_d;
    end
  end

  assign spi_cs_n  = cs_n_q;
  assign req_ready = (st_q == S_IDLE);
  assign busy      = (st_q != S_IDLE);
  assign done      = (st_q == S_FIN);
  assign prot_err  = prot_q;
  assign timeout   = tmo_q;

  // R1: no frame is open while idle
  assert_cs_idle_R1: assert property (@(posedge clk) disable iff (!rst_i)
    (st_q == S_IDLE) |-> spi_cs_n);

  // R9: clock is low whenever chip select is released
  assert_sclk_low_R9: assert property (@(posedge clk) disable iff (!rst_i)
    spi_cs_n |-> !spi_sclk);

  // R10: completion is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_i)
    done |=> !done);

  // R6: data is only requested while bytes are owed on a page program
  assert_ready_owed_R6: assert property (@(posedge clk) disable iff (!rst_i)
    wr_ready |-> ((rem_q != '0) && (op_q == OP_PAGE)));

  // R3: a refused request never opens a write-enable frame
  assert_prot_quiet_R3: assert property (@(posedge clk) disable iff (!rst_i)
    (prot_q && busy) |-> spi_cs_n);

  // R8: a timeout is only raised with the flash still reporting busy
  assert_tmo_busy_R8: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(tmo_q) |-> stat_q[0]);

endmodule

// File: tb/flash_pe_seq_bench.sv
`timescale 1ns/1ps
module flash_pe_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [1:0]  req_op;
  logic [21:0] req_addr;
  logic [7:0]  req_len_m1;
  logic [7:0]  wr_data;
  logic        wr_valid, wr_ready;
  logic [15:0] poll_interval, poll_limit;
  logic        busy, done, prot_err, timeout;
  logic        sclk, cs_n, mosi, miso;

  always #10 clk = ~clk;

  flash_pe_seq u_flash_pe_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len_m1(req_len_m1),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .poll_interval(poll_interval), .poll_limit(poll_limit),
    .busy(busy), .done(done), .prot_err(prot_err), .timeout(timeout),
    .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // data stream source: byte value follows the count of taken bytes
  logic [31:0] taken = 0;
  always @(posedge clk) if (wr_valid && wr_ready) taken <= taken + 1;
  assign wr_data = taken[7:0];

  // flash model and scoreboard monitor
  typedef struct {
    logic [7:0]  opc;
    logic [23:0] addr;
    int          n;
    logic [7:0]  sum;
  } frame_t;
  frame_t exp_q[$];

  logic [3:0]  m_bp = 0;
  bit          m_wel = 0;
  int          busy_cfg = 0, busy_left = 0;
  int          m_bits = 0, m_n = 0, st_reads = 0, proto_bad = 0;
  logic [7:0]  m_sh = 0, m_op = 0, m_sum = 0, m_sr = 0;
  logic [23:0] m_addr = 0;

  always @(negedge cs_n) begin
    if (sclk) proto_bad++;
    m_bits = 0; m_n = 0; m_sum = 0; m_addr = 0;
  end

  always @(posedge sclk) begin
    if (cs_n) proto_bad++;
    else begin
      m_sh = {m_sh[6:0], mosi};
      m_bits++;
      if (m_bits % 8 == 0) begin
        if (m_bits == 8) begin
          m_op = m_sh;
          if (m_sh == 8'h05) m_sr = {2'b00, m_bp, m_wel, (busy_left > 0)};
        end else if (m_bits <= 32 && m_op != 8'h05 && m_op != 8'h06 && m_op != 8'hC7)
          m_addr = {m_addr[15:0], m_sh};
        else begin
          m_n++;
          m_sum = m_sum + m_sh;
        end
      end
    end
  end

  always @(negedge sclk) begin
    if (!cs_n && m_op == 8'h05 && m_bits >= 8) begin
      miso = m_sr[7];
      m_sr = {m_sr[6:0], 1'b0};
    end
  end

  always @(posedge cs_n) begin
    if (sclk) proto_bad++;
    if (m_bits > 0) begin
      chk("R9", "frame bit count multiple of 8", m_bits % 8, 0);
      if (m_op == 8'h05) begin
        st_reads++;
        if (busy_left > 0) busy_left--;
      end else if (exp_q.size() == 0) begin
        chk("R3", "unexpected frame opcode", m_op, -1);
      end else begin
        frame_t e;
        e = exp_q.pop_front();
        chk("R4 R5", "frame opcode", m_op, e.opc);
        chk("R5", "frame address", m_addr, e.addr);
        chk("R6", "frame data bytes", m_n, e.n);
        chk("R6", "frame data sum", m_sum, e.sum);
        if (m_op != 8'h06) chk("R4", "write enable latched before command", m_wel, 1);
        if (m_op == 8'h06) m_wel = 1;
        else begin
          m_wel = 0;
          busy_left = busy_cfg;
        end
      end
    end
  end

  function automatic logic [7:0] code_of(int op);
    case (op)
      0: return 8'h02;
      1: return 8'h20;
      2: return 8'hD8;
      default: return 8'hC7;
    endcase
  endfunction

  // driver: push expected frames, issue the request, judge the outcome
  task automatic run_req(string req, int op, int addr, int len_m1, int bp,
                         int bcfg, int limit, bit e_prot, bit e_tmo,
                         int e_n, int e_reads);
    frame_t w, c;
    logic [31:0] base;
    int waited;
    base = taken;
    m_bp = 4'(bp); busy_cfg = bcfg; busy_left = 0; st_reads = 0;
    poll_limit = 16'(limit);
    if (!e_prot) begin
      w.opc = 8'h06; w.addr = 0; w.n = 0; w.sum = 0;
      c.opc = code_of(op);
      c.addr = (op == 3) ? 24'h0 : 24'(addr);
      c.n = e_n; c.sum = 0;
      for (int i = 0; i < e_n; i++) c.sum = c.sum + 8'(base + 32'(i));
      exp_q.push_back(w);
      exp_q.push_back(c);
    end
    @(negedge clk);
    req_op = 2'(op); req_addr = 22'(addr); req_len_m1 = 8'(len_m1);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", "busy after accept", busy, 1);
    chk("R10", "req_ready while busy", req_ready, 0);
    waited = 0;
    while (!done && waited < 100000) begin
      @(negedge clk);
      waited++;
    end
    chk(req, "done seen", done, 1);
    chk("R3", "prot_err", prot_err, e_prot);
    chk("R8", "timeout", timeout, e_tmo);
    chk("R2 R7", "status reads", st_reads, e_reads);
    chk("R6", "stream bytes taken", taken - base, e_n);
    chk(req, "expected frames left", exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    chk("R10", "done one cycle", done, 0);
    chk("R10", "idle after done", busy, 0);
    chk("R10", "flags held", prot_err, e_prot);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 0; req_addr = 0; req_len_m1 = 0;
    wr_valid = 1'b1; poll_interval = 16'd20; poll_limit = 16'd10; miso = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "cs_n in reset", cs_n, 1);
    chk("R1", "sclk in reset", sclk, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "done after reset", done, 0);
    chk("R1", "req_ready after reset", req_ready, 1);
    chk("R1", "wr_ready after reset", wr_ready, 0);
    chk("R1", "cs_n after reset", cs_n, 1);

    // R2 R4 R5 R7: aligned program, two busy polls then clear
    run_req("R7", 0, 'h012300, 15, 0, 2, 10, 0, 0, 16, 4);
    // R6: clipped at page end (0xF0 + 32 -> 16 bytes)
    run_req("R6", 0, 'h0456F0, 31, 0, 0, 10, 0, 0, 16, 2);
    // R6: a full page
    run_req("R6", 0, 'h000100, 255, 0, 0, 10, 0, 0, 256, 2);
    // R6: last byte of a page, long request -> one byte
    run_req("R6", 0, 'h0002FF, 9, 0, 0, 10, 0, 0, 1, 2);
    // R5: erase kinds
    run_req("R5", 1, 'h001234, 0, 0, 1, 10, 0, 0, 0, 3);
    run_req("R5", 2, 'h3F0000, 0, 0, 0, 10, 0, 0, 0, 2);
    run_req("R5", 3, 0, 0, 0, 3, 10, 0, 0, 0, 5);
    // R3: protection regions
    run_req("R3", 2, 'h3F0000, 0, 1, 0, 10, 1, 0, 0, 1);
    run_req("R3", 0, 'h3E0010, 3, 1, 0, 10, 0, 0, 4, 2);
    run_req("R3", 1, 'h3BFFFF, 0, 3, 0, 10, 0, 0, 0, 2);
    run_req("R3", 1, 'h3C0000, 0, 3, 0, 10, 1, 0, 0, 1);
    run_req("R3", 3, 0, 0, 2, 0, 10, 1, 0, 0, 1);
    run_req("R3", 0, 'h000000, 7, 15, 0, 10, 1, 0, 0, 1);
    run_req("R3", 1, 'h000000, 0, 7, 0, 10, 1, 0, 0, 1);
    // R8: flash stays busy past the limit
    run_req("R8", 1, 'h002000, 0, 0, 10, 3, 0, 1, 0, 4);
    // R8: clear status on the last allowed poll wins over the limit
    run_req("R8", 1, 'h003000, 0, 0, 2, 3, 0, 0, 0, 4);
    // R9: link shape over the whole run
    chk("R9", "clock edges outside frame or frame edges with clock high", proto_bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule